// File: doc/BRIEF.md
# Serial Audio Slot Receiver

This block takes one serial audio data line and turns each time slot into a 32-bit received word. An external clock and frame generator supplies, as single-cycle strobes in the system clock domain, the rising and falling serial clock edges and a marker that flags the first bit of each slot. The receiver counts bits against the configured slot length. When a slot completes, it picks the data bits out of that slot, sets their order, places them in the output word and fills the spare bit positions by a chosen rule.

The host side sees a data register and two flags. A ready flag reports that a new word is waiting. A sticky overrun flag reports that a word arrived before the previous one was taken. The receiver has two capture modes: a normal mode that samples on rising edges, and a pulse-density mode that takes one bit on every edge. A loopback select feeds the receiver from a transmitter's output bit instead of the data pin, for self-test. All configuration inputs are expected to stay static while a slot is in progress.

Top module: `srx_receiver`

## Requirements
- R1: After reset, rx_data is 0 and rx_ready and rx_overrun are low.
- R2: With mode 0 (receive), one bit of the selected source is taken at each cycle with sck_rise high, and sck_fall is ignored. A bit taken while slot_start is high is the first bit of a new slot and restarts the count. Bits taken before the first slot_start are dropped. A slot holds 8, 16, 24 or 32 bits for slot_size codes 0, 1, 2 and 3. The word is updated at the clock edge that takes the last bit of the slot.
- R3: With mode 2 (pulse-density capture), one bit is taken at each cycle with either sck_rise or sck_fall high. Slot counting is the same as in R2.
- R4: With mode 1 or mode 3, no bits are taken, and rx_data and rx_ready do not change.
- R5: word_size codes 0 to 4 select 8, 16, 18, 20 and 24 data bits, and codes 5, 6 and 7 select 32. The number of bits used is the smaller of this size and the slot length.
- R6: With slot_left high, the data bits are the first-arriving bits of the slot. With slot_left low, they are the last-arriving bits.
- R7: With lsb_first low, the first data bit to arrive is the most significant bit. With lsb_first high, it is the least significant bit.
- R8: With word_left low, the data sits in bits [d-1:0] of rx_data. With word_left high, it sits in bits [31:32-d].
- R9: The spare bits of rx_data are filled according to ext_rule: 0 gives zeros, 1 gives ones, 2 gives copies of the data MSB, and 3 gives copies of the data LSB.
- R10: rx_ready rises when a word completes. It is cleared by rd_en unless a word completes in the same cycle, in which case it stays high.
- R11: When a word completes while rx_ready is high and rd_en is low, rx_overrun is set and the newer word replaces the older one in rx_data.
- R12: rx_overrun stays set until ovr_clr. If ovr_clr arrives in the same cycle as a new overrun, the flag stays set.
- R13: With loop_en high, bits are taken from lb_bit and sdi is ignored. With loop_en low, bits are taken from sdi and lb_bit is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | 0 receive, 2 pulse-density capture, 1/3 idle |
| slot_size | input | 2 | Slot length code (8/16/24/32 bits) |
| word_size | input | 3 | Data size code |
| slot_left | input | 1 | Take data from the start of the slot |
| word_left | input | 1 | Place data at the top of the word |
| lsb_first | input | 1 | First data bit is the LSB |
| ext_rule | input | 2 | Spare-bit fill rule |
| loop_en | input | 1 | Select lb_bit as data source |
| sck_rise | input | 1 | Serial clock rising-edge strobe |
| sck_fall | input | 1 | Serial clock falling-edge strobe |
| slot_start | input | 1 | First bit of a slot marker |
| sdi | input | 1 | Serial data pin |
| lb_bit | input | 1 | Transmitter loopback bit |
| rd_en | input | 1 | Data register read strobe |
| ovr_clr | input | 1 | Overrun flag clear strobe |
| rx_data | output | 32 | Last received, formatted word |
| rx_ready | output | 1 | Word waiting |
| rx_overrun | output | 1 | Sticky overrun flag |

## Verification
A bit counter that drifts from the slot marker shows up on the very next word: rx_ready appears one or more bits too early or too late, and every bit of rx_data is shifted. An error in field extraction, bit reversal or fill corrupts rx_data in the same cycle that rx_ready rises, so each word is compared in full at that edge across random configurations. An error in the flag logic shows up one cycle after a completion, a read or a clear, which the directed read/overrun cases probe at their exact edges.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int WORD_W = 32;

  localparam logic [1:0] MODE_RX  = 2'd0;
  localparam logic [1:0] MODE_PDM = 2'd2;

  // slot length in bits from its 2-bit code
  function automatic int slot_bits(input logic [1:0] code);
    return 8 * (int'(code) + 1);
  endfunction

  // number of data bits: word size clipped to the slot length
  function automatic int data_bits(input logic [2:0] wcode, input logic [1:0] scode);
    int w;
    case (wcode)
      3'd0: w = 8;
      3'd1: w = 16;
      3'd2: w = 18;
      3'd3: w = 20;
      3'd4: w = 24;
      default: w = WORD_W;
    endcase
    return (w < slot_bits(scode)) ? w : slot_bits(scode);
  endfunction

  // raw: slot bits, earliest arrival at index len-1, latest at 0
  function automatic logic [WORD_W-1:0] fmt_word(
      input logic [WORD_W-1:0] raw, input int len, input int d,
      input logic slot_left, input logic lsb_first,
      input logic word_left, input logic [1:0] ext);
    logic [WORD_W-1:0] f, r, mask, res;
    logic fill;
    f = slot_left ? (raw >> (len - d)) : raw;
    mask = (d >= WORD_W) ? '1 : ((WORD_W'(1) << d) - WORD_W'(1));
    f = f & mask;
    if (lsb_first) begin
      for (int i = 0; i < WORD_W; i++) r[i] = f[WORD_W-1-i];
      f = r >> (WORD_W - d);
    end
    case (ext)
      2'd0: fill = 1'b0;
      2'd1: fill = 1'b1;
      2'd2: fill = f[d-1];
      default: fill = f[0];
    endcase
    if (word_left)
      res = (f << (WORD_W - d)) | (fill ? ~(mask << (WORD_W - d)) : '0);
    else
      res = f | (fill ? ~mask : '0);
    return res;
  endfunction
endpackage

// File: rtl/srx_bit_sampler.sv
module srx_bit_sampler
  import srx_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic [1:0]   slot_size,
  input  logic         loop_en,
  input  logic         sck_rise,
  input  logic         sck_fall,
  input  logic         slot_start,
  input  logic         sdi,
  input  logic         lb_bit,
  output logic [W-1:0] raw_slot,
  output logic         slot_done
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  shreg;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cur;
  logic          armed;
  logic          sample_en;
  logic          take;
  logic          in_bit;
  logic          last_bit;

  assign sample_en = ((mode == MODE_RX)  && sck_rise) ||
                     ((mode == MODE_PDM) && (sck_rise || sck_fall));
  assign in_bit    = loop_en ? lb_bit : sdi;
  assign cur       = slot_start ? '0 : cnt;
  assign take      = sample_en && (armed || slot_start);
  assign last_bit  = (int'(cur) == slot_bits(slot_size) - 1);
  assign slot_done = take && last_bit;
  assign raw_slot  = {shreg[W-2:0], in_bit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
      armed <= 1'b0;
    end else if (take) begin
      shreg <= raw_slot;
      armed <= 1'b1;
      cnt   <= last_bit ? '0 : cur + CW'(1);
    end
  end

  // R2: the bit counter never passes the largest slot
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < W);
  // R2/R3: a slot only completes on a serial clock edge strobe
  a_r3_done_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    slot_done |-> (sck_rise || sck_fall));
endmodule

// File: rtl/srx_word_formatter.sv
module srx_word_formatter
  import srx_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0] raw_slot,
  input  logic [1:0]   slot_size,
  input  logic [2:0]   word_size,
  input  logic         slot_left,
  input  logic         lsb_first,
  input  logic         word_left,
  input  logic [1:0]   ext_rule,
  output logic [W-1:0] word
);
  int len_c;
  int dat_c;

  always_comb begin
    len_c = slot_bits(slot_size);
    dat_c = data_bits(word_size, slot_size);
    word  = fmt_word(raw_slot, len_c, dat_c, slot_left, lsb_first, word_left, ext_rule);
  end

  // R9: fill with ones leaves at least W-d ones in the word
  always_comb begin
    if (ext_rule == 2'd1)
      a_r9_ones_fill: assert ($countones(word) >= W - dat_c);
  end
endmodule

// File: rtl/srx_rx_flags.sv
module srx_rx_flags #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         word_done,
  input  logic [W-1:0] word_in,
  input  logic         rd_en,
  input  logic         ovr_clr,
  output logic [W-1:0] rx_data,
  output logic         rx_ready,
  output logic         rx_overrun
);
  logic new_overrun;
  assign new_overrun = word_done && rx_ready && !rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data    <= '0;
      rx_ready   <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      if (word_done) rx_data <= word_in;
      if (word_done)  rx_ready <= 1'b1;
      else if (rd_en) rx_ready <= 1'b0;
      if (new_overrun)  rx_overrun <= 1'b1;
      else if (ovr_clr) rx_overrun <= 1'b0;
    end
  end

  a_r10_ready_on_word: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> rx_ready);
  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !word_done) |=> !rx_ready);
  a_r11_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rx_ready && !rd_en) |=> rx_overrun);
  a_r12_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !ovr_clr) |=> rx_overrun);
  a_r11_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !word_done |=> $stable(rx_data));
endmodule

// File: rtl/srx_receiver.sv
module srx_receiver
  import srx_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic [1:0]   slot_size,
  input  logic [2:0]   word_size,
  input  logic         slot_left,
  input  logic         word_left,
  input  logic         lsb_first,
  input  logic [1:0]   ext_rule,
  input  logic         loop_en,
  input  logic         sck_rise,
  input  logic         sck_fall,
  input  logic         slot_start,
  input  logic         sdi,
  input  logic         lb_bit,
  input  logic         rd_en,
  input  logic         ovr_clr,
  output logic [W-1:0] rx_data,
  output logic         rx_ready,
  output logic         rx_overrun
);
  logic [W-1:0] raw_slot;
  logic [W-1:0] fmt_out;
  logic         slot_done;

  srx_bit_sampler #(.W(W)) u_sampler (
    .clk(clk), .rst_n(rst_n), .mode(mode), .slot_size(slot_size),
    .loop_en(loop_en), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .slot_start(slot_start), .sdi(sdi), .lb_bit(lb_bit),
    .raw_slot(raw_slot), .slot_done(slot_done)
  );

  srx_word_formatter #(.W(W)) u_fmt (
    .raw_slot(raw_slot), .slot_size(slot_size), .word_size(word_size),
    .slot_left(slot_left), .lsb_first(lsb_first), .word_left(word_left),
    .ext_rule(ext_rule), .word(fmt_out)
  );

  srx_rx_flags #(.W(W)) u_flags (
    .clk(clk), .rst_n(rst_n), .word_done(slot_done), .word_in(fmt_out),
    .rd_en(rd_en), .ovr_clr(ovr_clr), .rx_data(rx_data),
    .rx_ready(rx_ready), .rx_overrun(rx_overrun)
  );

  // R4: idle modes leave data and ready untouched
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[0] && !rd_en) |=> ($stable(rx_ready) && $stable(rx_data)));
endmodule

// File: tb/srx_receiver_tb.sv
module srx_receiver_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0, slot_size = 2'd3, ext_rule = 2'd0;
  logic [2:0] word_size = 3'd5;
  logic slot_left = 0, word_left = 0, lsb_first = 0, loop_en = 0;
  logic sck_rise = 0, sck_fall = 0, slot_start = 0, sdi = 0, lb_bit = 0;
  logic rd_en = 0, ovr_clr = 0;
  logic [31:0] rx_data;
  logic rx_ready, rx_overrun;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  srx_receiver u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .slot_size(slot_size),
    .word_size(word_size), .slot_left(slot_left), .word_left(word_left),
    .lsb_first(lsb_first), .ext_rule(ext_rule), .loop_en(loop_en),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .slot_start(slot_start),
    .sdi(sdi), .lb_bit(lb_bit), .rd_en(rd_en), .ovr_clr(ovr_clr),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_overrun(rx_overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int m_len(input logic [1:0] sc);
    case (sc) 2'd0: return 8; 2'd1: return 16; 2'd2: return 24; default: return 32; endcase
  endfunction

  function automatic int m_dat(input logic [2:0] wc, input logic [1:0] sc);
    int w;
    w = (wc == 0) ? 8 : (wc == 1) ? 16 : (wc == 2) ? 18 : (wc == 3) ? 20 : (wc == 4) ? 24 : 32;
    return (m_len(sc) < w) ? m_len(sc) : w;
  endfunction

  // pat[k] is the k-th bit to arrive in the slot
  function automatic logic [31:0] model(input logic [31:0] pat);
    int L, d, first;
    logic [31:0] v, o;
    logic fill;
    L = m_len(slot_size); d = m_dat(word_size, slot_size);
    first = slot_left ? 0 : L - d;
    v = '0;
    for (int j = 0; j < d; j++) begin
      if (lsb_first) v[j] = pat[first + j];
      else           v[d-1-j] = pat[first + j];
    end
    fill = (ext_rule == 0) ? 1'b0 : (ext_rule == 1) ? 1'b1 :
           (ext_rule == 2) ? v[d-1] : v[0];
    for (int i = 0; i < 32; i++) begin
      if (word_left) o[i] = (i >= 32 - d) ? v[i - (32 - d)] : fill;
      else           o[i] = (i < d) ? v[i] : fill;
    end
    return o;
  endfunction

  task automatic send(input logic [31:0] pat, input int n, input bit noise,
                      input bit rd_last, input bit clr_last);
    bit pdm;
    pdm = (mode == 2'd2);
    for (int k = 0; k < n; k++) begin
      lb_bit     = loop_en ? pat[k] : ~pat[k];
      sdi        = loop_en ? ~pat[k] : pat[k];
      sck_rise   = pdm ? (k % 2 == 0) : 1'b1;
      sck_fall   = pdm ? (k % 2 == 1) : 1'b0;
      slot_start = (k == 0);
      rd_en      = rd_last && (k == n - 1);
      ovr_clr    = clr_last && (k == n - 1);
      @(negedge clk);
      sck_rise = 0; sck_fall = 0; slot_start = 0; rd_en = 0; ovr_clr = 0;
      if (noise && !pdm && k != n - 1) begin
        sck_fall = 1'b1; sdi = ~sdi; lb_bit = ~lb_bit;
        @(negedge clk);
        sck_fall = 1'b0;
      end
    end
  endtask

  task automatic rd();
    rd_en = 1; @(negedge clk); rd_en = 0;
  endtask

  task automatic clr();
    ovr_clr = 1; @(negedge clk); ovr_clr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] p, q, keep;
    void'($urandom(32'h5eed1));
    repeat (3) @(negedge clk);
    // R1
    chk("R1 data", rx_data, 32'h0);
    chk("R1 ready", {31'd0, rx_ready}, 32'd1 - 32'd1);
    chk("R1 overrun", {31'd0, rx_overrun}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: bits before first slot_start are dropped; fall strobes ignored
    sdi = 1; sck_rise = 1; @(negedge clk); sck_rise = 0;
    chk("R2 unarmed", {31'd0, rx_ready}, 32'd0);
    p = 32'hA5C3_1E77;
    send(p, 32, 1, 0, 0);
    chk("R2 rx 32-bit slot noise", rx_data, model(p));
    chk("R10 ready set", {31'd0, rx_ready}, 32'd1);
    rd();
    chk("R10 read clears", {31'd0, rx_ready}, 32'd0);

    // R2: restart by slot_start after a partial slot
    slot_size = 2'd1; word_size = 3'd1;
    send(32'hFFFF_FFFF, 5, 0, 0, 0);
    chk("R2 partial no word", {31'd0, rx_ready}, 32'd0);
    p = 32'h0000_3C5A;
    send(p, 16, 0, 0, 0);
    chk("R2 restart slot", rx_data, model(p));
    rd();

    // R3: PDM on both edges
    mode = 2'd2; slot_size = 2'd0; word_size = 3'd0;
    p = 32'h0000_00B4;
    send(p, 8, 0, 0, 0);
    chk("R3 pdm word", rx_data, model(p));
    rd();
    mode = 2'd0;

    // R4: idle modes capture nothing
    keep = rx_data;
    mode = 2'd1;
    send(32'h1234_5678, 8, 0, 0, 0);
    chk("R4 mode1 ready", {31'd0, rx_ready}, 32'd0);
    chk("R4 mode1 data", rx_data, keep);
    mode = 2'd3;
    send(32'h8765_4321, 8, 0, 0, 0);
    chk("R4 mode3 data", rx_data, keep);
    mode = 2'd0;

    // R13: loopback
    loop_en = 1; slot_size = 2'd3; word_size = 3'd4;
    p = 32'hC0DE_F00D;
    send(p, 32, 0, 0, 0);
    chk("R13 loopback", rx_data, model(p));
    rd();
    loop_en = 0;

    // R11/R12: overrun, overwrite, sticky, clear
    slot_size = 2'd1; word_size = 3'd1; ext_rule = 2'd0;
    p = 32'h0000_1111; q = 32'h0000_7E81;
    send(p, 16, 0, 0, 0);
    send(q, 16, 0, 0, 0);
    chk("R11 overrun set", {31'd0, rx_overrun}, 32'd1);
    chk("R11 newer word kept", rx_data, model(q));
    rd();
    chk("R12 sticky after read", {31'd0, rx_overrun}, 32'd1);
    clr();
    chk("R12 cleared", {31'd0, rx_overrun}, 32'd0);
    // R10: read in the completion cycle keeps ready, no overrun
    send(p, 16, 0, 0, 0);
    send(q, 16, 0, 1, 0);
    chk("R10 read+word ready", {31'd0, rx_ready}, 32'd1);
    chk("R11 no overrun on read", {31'd0, rx_overrun}, 32'd0);
    // R12: clear in same cycle as new overrun keeps flag
    send(p, 16, 0, 0, 1);
    chk("R12 set wins", {31'd0, rx_overrun}, 32'd1);
    clr(); rd();

    // R5-R9 directed corners
    slot_size = 2'd2; word_size = 3'd2; slot_left = 1; lsb_first = 1;
    word_left = 1; ext_rule = 2'd2;
    p = 32'h00A1_B2C3;
    send(p, 24, 0, 0, 0);
    chk("R5 R6 R7 R8 R9 18-in-24", rx_data, model(p));
    rd();
    word_left = 0; ext_rule = 2'd3; slot_left = 0; lsb_first = 0;
    p = 32'h00F0_0F01;
    send(p, 24, 0, 0, 0);
    chk("R9 lsb fill", rx_data, model(p));
    rd();

    // random configurations
    for (int it = 0; it < 80; it++) begin
      mode      = ($urandom % 2) ? 2'd2 : 2'd0;
      slot_size = 2'($urandom % 4);
      word_size = 3'($urandom % 8);
      slot_left = 1'($urandom % 2);
      word_left = 1'($urandom % 2);
      lsb_first = 1'($urandom % 2);
      ext_rule  = 2'($urandom % 4);
      loop_en   = 1'($urandom % 2);
      p = $urandom;
      send(p, m_len(slot_size), 1'($urandom % 2), 0, 0);
      chk("R5 R6 R7 R8 R9 random", rx_data, model(p));
      chk("R10 random ready", {31'd0, rx_ready}, 32'd1);
      rd();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule